// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects level-sensitive interrupt requests from PCI device slots and merges them onto four interrupt channels. Each slot has four pins, INTA to INTD. A fixed rotation that depends on the slot number picks the channel for each slot and pin. Each channel has a routing register that either disables the channel or steers it onto one of sixteen ISA interrupt lines.

Several slots may assert on one channel, and several channels may target the same ISA line. The block keeps a record of which slot is asserting on each channel and line. As a result, a shared line stays high until the last source lets go.

Requests arrive one per cycle as a slot number, a pin code and a level. The routing registers are written and read through a small byte port. Toward the interrupt controller, the block drives a sixteen-bit level vector and one-cycle raise and lower pulses for each line.

Top module: `pirq_router`

## Requirements
- R1: A routing-register write stores the written byte ANDed with 0x8F. Readback on `cfg_rdata` therefore always shows bits 6:4 as zero. Bits 3:0 hold the IRQ number and bit 7 is the disable flag.
- R2: After reset, all four routing registers read 0x80 and `irq_level`, `irq_raise` and `irq_lower` are all zero.
- R3: Only IRQ numbers whose bit is set in 0xDEF8 are legal. A write that selects an enabled route to IRQ 0, 1, 2, 8 or 13 is ignored, so the register keeps its old value. An illegal line is never driven high.
- R4: A channel whose bit 7 is set is disabled, and requests that map to it change nothing. A write with bit 7 set to a channel that is already disabled is ignored, so the register keeps its old value.
- R5: A request on slot s with pin code p (0 = INTA, 1 = INTB, 2 = INTC, 3 = INTD) lands on channel (s + p + 1 − SWIZZLE_OFFSET) mod 4. SWIZZLE_OFFSET defaults to 2.
- R6: Each channel and IRQ pair keeps one assertion bit per slot. A line stays high while any slot still holds an assertion bit on it.
- R7: When two channels route to one IRQ, the line stays high until neither channel has an asserting slot.
- R8: `irq_raise[i]` pulses for exactly one cycle when line i goes from low to high, and `irq_lower[i]` pulses for one cycle when it goes from high to low. Both never pulse together.
- R9: A request or register write applied at a clock edge is visible on `irq_level` right after that edge. Without either stimulus, `irq_level` holds its value.
- R10: A channel may be moved to another IRQ or disabled. If no other enabled channel still routes to the old IRQ, the moved channel's assertion bits on the old IRQ are cleared, which can drop that line. If another enabled channel still routes there, the bits are kept.
- R11: A write whose masked value equals the current register value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | A slot interrupt level change is presented this cycle |
| src_slot | input | SLOT_W | Slot number of the request |
| src_pin | input | 2 | Pin code, 0 = INTA to 3 = INTD |
| src_level | input | 1 | New level of that pin, 1 = asserted |
| cfg_we | input | 1 | Write strobe for the routing register |
| cfg_sel | input | 2 | Routing register (channel) select |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Selected routing register contents |
| irq_level | output | 16 | Current level of every ISA line |
| irq_raise | output | 16 | One-cycle pulse on a rising line |
| irq_lower | output | 16 | One-cycle pulse on a falling line |

## Verification
A corrupted assertion bit cannot be read directly from outside the block. It shows up only as a line that fails to fall, or falls too early, and only when the last holder of a shared line deasserts or when a channel is moved away. For this reason the sequences deliberately drain shared lines one source at a time and move channels while they are asserting. A wrong routing register is visible on the read port at once, and on `irq_level` one cycle after the next request that maps through it. A wrong edge-detect history shows as a missing or extra pulse in the same cycle as the level change.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_W    = 2;
    localparam int NUM_IRQ = 16;
    localparam int IRQ_W   = 4;

    localparam logic [7:0]         ROUTE_MASK = 8'h8F;
    localparam logic [7:0]         ROUTE_RST  = 8'h80;
    localparam logic [NUM_IRQ-1:0] LEGAL_IRQ  = 16'hDEF8;

    typedef logic [7:0] route_t;

    typedef struct packed {
        logic             valid;
        logic [CH_W-1:0]  ch;
        logic [IRQ_W-1:0] irq;
    } release_t;

    function automatic logic irq_legal(input logic [IRQ_W-1:0] irq);
        return LEGAL_IRQ[irq];
    endfunction

    // rotation of slot/pin onto a channel, modulo 4
    function automatic logic [CH_W-1:0] pick_channel(
        input logic [CH_W-1:0] slot_lo,
        input logic [1:0]      pin,
        input logic [CH_W-1:0] off_lo
    );
        return slot_lo + pin + 2'd1 - off_lo;
    endfunction

endpackage

// File: rtl/pirq_router_cfg.sv
module pirq_router_cfg
    import pirq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CH_W-1:0]               cfg_sel,
    input  logic [7:0]                    cfg_wdata,
    output logic [NUM_CH-1:0][7:0]        route,
    output release_t                      rel
);

    route_t route_q [NUM_CH];
    route_t wmask;
    route_t old;
    logic   accept;
    logic   shared;

    always_comb begin
        wmask  = cfg_wdata & ROUTE_MASK;
        old    = route_q[cfg_sel];
        accept = 1'b0;
        if (cfg_we && (wmask != old)) begin
            if (wmask[7]) accept = !old[7];
            else          accept = irq_legal(wmask[IRQ_W-1:0]);
        end
        shared = 1'b0;
        for (int j = 0; j < NUM_CH; j++) begin
            if ((j != int'(cfg_sel)) && !route_q[j][7] &&
                (route_q[j][IRQ_W-1:0] == old[IRQ_W-1:0]))
                shared = 1'b1;
        end
        rel.valid = accept && !old[7] && !shared;
        rel.ch    = cfg_sel;
        rel.irq   = old[IRQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NUM_CH; j++) route_q[j] <= ROUTE_RST;
        end else if (accept) begin
            route_q[cfg_sel] <= wmask;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_out
            assign route[g] = route_q[g];
        end
    endgenerate

endmodule

// File: rtl/pirq_router_track.sv
module pirq_router_track
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS      = 32,
    parameter int SWIZZLE_OFFSET = 2,
    localparam int SLOT_W        = $clog2(NUM_SLOTS)
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          src_valid,
    input  logic [SLOT_W-1:0]             src_slot,
    input  logic [1:0]                    src_pin,
    input  logic                          src_level,
    input  logic [NUM_CH-1:0][7:0]        route,
    input  release_t                      rel,
    output logic [NUM_IRQ-1:0]            level
);

    localparam logic [CH_W-1:0] OFF_LO = SWIZZLE_OFFSET[CH_W-1:0];

    logic [NUM_CH-1:0][NUM_IRQ-1:0][NUM_SLOTS-1:0] held_q;
    logic [CH_W-1:0]  ch;
    route_t           r;
    logic             hit;

    always_comb begin
        ch  = pick_channel(src_slot[CH_W-1:0], src_pin, OFF_LO);
        r   = route[ch];
        hit = src_valid && !r[7] && irq_legal(r[IRQ_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            if (hit) held_q[ch][r[IRQ_W-1:0]][src_slot] <= src_level;
            if (rel.valid) held_q[rel.ch][rel.irq] <= '0;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            level[i] = 1'b0;
            for (int c = 0; c < NUM_CH; c++) level[i] = level[i] | (|held_q[c][i]);
        end
    end

endmodule

// File: rtl/pirq_router_edge.sv
module pirq_router_edge
    import pirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] level,
    output logic [NUM_IRQ-1:0] raise,
    output logic [NUM_IRQ-1:0] lower
);

    logic [NUM_IRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    assign raise = level & ~prev_q;
    assign lower = prev_q & ~level;

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS      = 32,
    parameter int SWIZZLE_OFFSET = 2,
    localparam int SLOT_W        = $clog2(NUM_SLOTS)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_valid,
    input  logic [SLOT_W-1:0]  src_slot,
    input  logic [1:0]         src_pin,
    input  logic               src_level,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic [15:0]        irq_level,
    output logic [15:0]        irq_raise,
    output logic [15:0]        irq_lower
);

    logic [NUM_CH-1:0][7:0] route;
    release_t               rel;

    pirq_router_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .route     (route),
        .rel       (rel)
    );

    pirq_router_track #(
        .NUM_SLOTS      (NUM_SLOTS),
        .SWIZZLE_OFFSET (SWIZZLE_OFFSET)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_slot  (src_slot),
        .src_pin   (src_pin),
        .src_level (src_level),
        .route     (route),
        .rel       (rel),
        .level     (irq_level)
    );

    pirq_router_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (irq_level),
        .raise (irq_raise),
        .lower (irq_lower)
    );

    assign cfg_rdata = route[cfg_sel];

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        src_valid,
    input logic        cfg_we,
    input logic [7:0]  cfg_rdata,
    input logic [15:0] irq_level,
    input logic [15:0] irq_raise,
    input logic [15:0] irq_lower
);

    assert_rd_masked_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & 8'h70) == 8'h00);

    assert_reset_route_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_rdata == ROUTE_RST));

    assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_level & ~LEGAL_IRQ) == '0);

    assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_raise & irq_lower) == '0);

    assert_raise_from_low_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_raise & $past(irq_level)) == '0);

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(src_valid) && !$past(cfg_we) && !$past(rst)) |-> $stable(irq_level));

endmodule

bind pirq_router pirq_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .irq_level (irq_level),
    .irq_raise (irq_raise),
    .irq_lower (irq_lower)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;

    typedef struct {
        logic [15:0] lvl;
        logic [15:0] rs;
        logic [15:0] lw;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_valid = 1'b0;
    logic [4:0]  src_slot = '0;
    logic [1:0]  src_pin = '0;
    logic        src_level = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] irq_level, irq_raise, irq_lower;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    pirq_router u_pirq_router (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_slot(src_slot), .src_pin(src_pin), .src_level(src_level),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_level(irq_level), .irq_raise(irq_raise), .irq_lower(irq_lower)
    );

    // monitor: compare outputs one cycle after each driven step
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (irq_level !== e.lvl || irq_raise !== e.rs || irq_lower !== e.lw) begin
                errors++;
                $display("FAIL %s level/raise/lower actual %h/%h/%h expected %h/%h/%h",
                         e.tag, irq_level, irq_raise, irq_lower, e.lvl, e.rs, e.lw);
            end
        end
    end

    task automatic push(input logic [15:0] l, input logic [15:0] r, input logic [15:0] w,
                        input string tag);
        exp_t e;
        e.lvl = l; e.rs = r; e.lw = w; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic src(input int s, input int p, input bit lv,
                       input logic [15:0] l, input logic [15:0] r, input logic [15:0] w,
                       input string tag);
        src_valid = 1'b1; src_slot = 5'(s); src_pin = 2'(p); src_level = lv;
        @(posedge clk); #2;
        src_valid = 1'b0;
        push(l, r, w, tag);
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input logic [7:0] d,
                      input logic [15:0] l, input logic [15:0] r, input logic [15:0] w,
                      input string tag);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        push(l, r, w, tag);
        @(negedge clk);
    endtask

    task automatic idle(input logic [15:0] l, input string tag);
        @(posedge clk); #2;
        push(l, 16'h0, 16'h0, tag);
        @(negedge clk);
    endtask

    task automatic rd(input int sel, input logic [7:0] e, input string tag);
        cfg_sel = 2'(sel);
        #1;
        checks++;
        if (cfg_rdata !== e) begin
            errors++;
            $display("FAIL %s readback reg%0d actual %h expected %h", tag, sel, cfg_rdata, e);
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        for (int k = 0; k < 4; k++) rd(k, 8'h80, "R2");
        idle(16'h0, "R2");
        // R4 disabled->disabled write ignored; R1 masking
        wr(0, 8'hF5, 16'h0, 16'h0, 16'h0, "R4");
        rd(0, 8'h80, "R4");
        wr(0, 8'h75, 16'h0, 16'h0, 16'h0, "R1");
        rd(0, 8'h05, "R1");
        // R5 slot1 INTA -> ch0 -> IRQ5
        src(1, 0, 1'b1, 16'h0020, 16'h0020, 16'h0, "R5");
        idle(16'h0020, "R9");
        // R6 two slots on one channel
        src(5, 0, 1'b1, 16'h0020, 16'h0, 16'h0, "R6");
        src(1, 0, 1'b0, 16'h0020, 16'h0, 16'h0, "R6");
        src(5, 0, 1'b0, 16'h0000, 16'h0, 16'h0020, "R8");
        idle(16'h0, "R8");
        // R5 rotation: slot0 INTC -> ch1, slot2 INTD -> ch0
        wr(1, 8'h09, 16'h0, 16'h0, 16'h0, "R5");
        src(0, 2, 1'b1, 16'h0200, 16'h0200, 16'h0, "R5");
        src(2, 3, 1'b1, 16'h0220, 16'h0020, 16'h0, "R5");
        // R3 illegal IRQ writes ignored
        wr(1, 8'h0D, 16'h0220, 16'h0, 16'h0, "R3");
        rd(1, 8'h09, "R3");
        wr(2, 8'h02, 16'h0220, 16'h0, 16'h0, "R3");
        rd(2, 8'h80, "R3");
        // R11 same masked value
        wr(1, 8'h79, 16'h0220, 16'h0, 16'h0, "R11");
        rd(1, 8'h09, "R11");
        // R7 sharing: ch2 also on IRQ5, slot3 INTA -> ch2
        wr(2, 8'h05, 16'h0220, 16'h0, 16'h0, "R7");
        src(3, 0, 1'b1, 16'h0220, 16'h0, 16'h0, "R7");
        src(2, 3, 1'b0, 16'h0220, 16'h0, 16'h0, "R7");
        src(3, 0, 1'b0, 16'h0200, 16'h0, 16'h0020, "R7");
        // R10 moving ch1 off IRQ9 releases it
        wr(1, 8'h0A, 16'h0000, 16'h0, 16'h0200, "R10");
        rd(1, 8'h0A, "R10");
        // R10 kept when another channel still routes there
        src(1, 0, 1'b1, 16'h0020, 16'h0020, 16'h0, "R10");
        wr(0, 8'h80, 16'h0020, 16'h0, 16'h0, "R10");
        rd(0, 8'h80, "R10");
        wr(0, 8'h85, 16'h0020, 16'h0, 16'h0, "R4");
        rd(0, 8'h80, "R4");
        // R4 requests to a disabled channel ignored
        src(1, 0, 1'b0, 16'h0020, 16'h0, 16'h0, "R4");
        idle(16'h0020, "R9");
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule